// File: doc/BRIEF.md
# Receive Buffer Packer with Length Limit

This block sits between a serial character receiver and a memory write port. It takes received 8-bit characters one at a time and packs them into 32-bit memory words. It writes those words into a series of receive buffers. A buffer opens when the first character for it arrives. The maximum byte count, the byte ordering, the address-type code and the buffer base address are all captured at that moment. The buffer closes when the maximum count is reached, or earlier on an end-of-frame or a receive error marker. When it closes, the block emits a one-cycle status pulse carrying the byte count and the reason for the close.

Each memory write carries a 4-bit function code. Bit 0 of that code is always 1, which marks the access as a DMA access. Byte lanes within a word follow one of three orderings: big-endian, little-endian, or big-endian with the two 16-bit halves swapped. A word that is only partly filled when its buffer closes is written with byte enables that cover only the lanes that hold data. While a memory write waits for acceptance, the character input is held off with a ready signal, so no character is lost.

The controller has four states. S_IDLE means no buffer is open. S_FILL accepts characters. S_WRITE presents a word to memory. S_CLOSE issues the status pulse. The transitions are:
- open: S_IDLE to S_FILL, when a character is waiting and the configuration is legal.
- word_done: S_FILL to S_WRITE, when the word is full or the character closes the buffer.
- resume: S_WRITE to S_FILL, when the write is accepted and the buffer stays open.
- finish: S_WRITE to S_CLOSE, when the write is accepted and the buffer closes.
- retire: S_CLOSE to S_IDLE, unconditionally.

Top module: `rxpk_top`

## Requirements
- R1: The byte-order field is cfg_ctrl[4:3]. Codes 10 and 11 select big-endian: the first byte of each word goes to mem_data[31:24], then [23:16], then [15:8], then [7:0]. mem_be bit i enables mem_data[8i+7:8i].
- R2: Code 01 selects little-endian: the first byte of each word goes to mem_data[7:0], then [15:8], then [23:16], then [31:24].
- R3: Code 00 selects the swapped order: the first byte of each word goes to mem_data[15:8], then [7:0], then [31:24], then [23:16].
- R4: A buffer never receives more than the captured maximum byte count. When the count is reached, the buffer closes, and the next character opens a new buffer.
- R5: A character flagged ch_eof or ch_err is stored as the last byte of its buffer. That buffer then closes with its actual count, and st_eof and st_err echo the two flags.
- R6: cfg_maxlen, cfg_ctrl and buf_base are captured only when a buffer opens. A change made while a buffer is open first applies to the next buffer.
- R7: A maximum length of zero is a configuration error. An odd maximum length while cfg_wide is 1 is also a configuration error. In either case cfg_error reads 1 from the next cycle, no buffer opens, and ch_ready stays 0.
- R8: mem_fc equals {cfg_ctrl[2:0], 1'b1} as captured for the current buffer.
- R9: The reserved bits cfg_ctrl[7:5] have no effect on any output.
- R10: A full word is written with mem_be = 4'hF. A word that is only partly filled when its buffer closes enables only the lanes that were filled, and disabled lanes read zero.
- R11: Each buffer close gives exactly one single-cycle st_valid pulse, with st_count equal to the number of bytes written to that buffer.
- R12: While mem_valid is high and mem_ready is low, ch_ready is 0 and mem_addr and mem_data hold steady.
- R13: Word k of a buffer is written to address buf_base + 4k, using the base captured when that buffer opened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_ctrl | input | 8 | [7:5] reserved, [4:3] byte order, [2:0] address type |
| cfg_maxlen | input | LW | Maximum bytes per buffer |
| cfg_wide | input | 1 | Characters are wider than 8 bits |
| buf_base | input | AW | Byte address of the next buffer |
| ch_valid | input | 1 | A character is offered |
| ch_ready | output | 1 | The character is taken on this edge |
| ch_data | input | 8 | Character byte |
| ch_eof | input | 1 | Character ends the frame |
| ch_err | input | 1 | Character carries a receive error |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | AW | Word byte address |
| mem_data | output | 32 | Write data |
| mem_be | output | 4 | Byte-lane enables |
| mem_fc | output | 4 | Function code for the access |
| st_valid | output | 1 | Buffer-close pulse |
| st_count | output | LW | Bytes written to the closed buffer |
| st_eof | output | 1 | The buffer closed on end-of-frame |
| st_err | output | 1 | The buffer closed on a receive error |
| cfg_error | output | 1 | The current length setting is illegal |

## Verification
The hardest situation to reach is a word write stalled by memory while the next character is already waiting. The stimulus creates it by holding mem_ready low across a word boundary with ch_valid asserted, then checks over several cycles that ch_ready stays low and that the request holds steady. A second hard case is a length change in the middle of a buffer. The stimulus reaches it by rewriting cfg_maxlen after the first bytes of a buffer have been taken, then checks that the old limit still closes that buffer and the new limit governs the next. A table of vectors covers every ordering code, close at the limit, early close, and a limit of one.

// File: rtl/rxpk_pkg.sv
package rxpk_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FILL  = 2'd1,
        S_WRITE = 2'd2,
        S_CLOSE = 2'd3
    } pk_state_t;

    localparam int BYTE_W  = 8;
    localparam int N_LANES = 4;
    localparam int LANE_W  = $clog2(N_LANES);
    localparam int WORD_W  = BYTE_W * N_LANES;

endpackage

// File: rtl/rxpk_lane_map.sv
module rxpk_lane_map
    import rxpk_pkg::*;
(
    input  logic [1:0]        order,
    input  logic [LANE_W-1:0] pos,
    output logic [LANE_W-1:0] lane
);

    always_comb begin
        unique case (order)
            2'b10, 2'b11: lane = ~pos;
            2'b01:        lane = pos;
            2'b00:        lane = (~pos) ^ 2'b10;
            default:      lane = ~pos;
        endcase
    end

endmodule

// File: rtl/rxpk_word_acc.sv
module rxpk_word_acc
    import rxpk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              clear,
    input  logic [LANE_W-1:0] lane,
    input  logic [BYTE_W-1:0] din,
    output logic [WORD_W-1:0] word,
    output logic [N_LANES-1:0] be
);

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word[g*BYTE_W +: BYTE_W] <= '0;
                be[g]                    <= 1'b0;
            end else if (clear) begin
                word[g*BYTE_W +: BYTE_W] <= '0;
                be[g]                    <= 1'b0;
            end else if (load && (lane == LANE_W'(g))) begin
                word[g*BYTE_W +: BYTE_W] <= din;
                be[g]                    <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/rxpk_len_ctrl.sv
module rxpk_len_ctrl #(
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          open,
    input  logic [LW-1:0] lim_in,
    input  logic          accept,
    output logic [LW-1:0] cnt,
    output logic [LW-1:0] lim,
    output logic          hit_lim
);

    logic [LW-1:0] cnt_nxt;
    assign cnt_nxt = cnt + 1'b1;
    assign hit_lim = (cnt_nxt == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            lim <= '0;
        end else if (open) begin
            cnt <= '0;
            lim <= lim_in;
        end else if (accept) begin
            cnt <= cnt_nxt;
        end
    end

    // R4
    cnt_within_lim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= lim);

    // R6
    lim_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !open |=> $stable(lim));

endmodule

// File: rtl/rxpk_top.sv
module rxpk_top
    import rxpk_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        cfg_ctrl,
    input  logic [LW-1:0]     cfg_maxlen,
    input  logic              cfg_wide,
    input  logic [AW-1:0]     buf_base,
    input  logic              ch_valid,
    output logic              ch_ready,
    input  logic [BYTE_W-1:0] ch_data,
    input  logic              ch_eof,
    input  logic              ch_err,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_data,
    output logic [N_LANES-1:0] mem_be,
    output logic [3:0]        mem_fc,
    output logic              st_valid,
    output logic [LW-1:0]     st_count,
    output logic              st_eof,
    output logic              st_err,
    output logic              cfg_error
);

    pk_state_t state, state_nxt;

    logic [1:0]        ord_q;
    logic [2:0]        at_q;
    logic [AW-1:0]     base_q;
    logic [LW-1:0]     widx_q;
    logic              close_q, eof_q, err_q, cfg_err_q;
    logic              cfg_ok, open, accept, last, word_done, wr_fire;
    logic [LW-1:0]     cnt, lim, cnt_nxt;
    logic              hit_lim;
    logic [LANE_W-1:0] lane;
    logic              unused_rsv;

    assign unused_rsv = ^cfg_ctrl[7:5];

    assign cfg_ok    = (cfg_maxlen != '0) && !(cfg_wide && cfg_maxlen[0]);
    assign open      = (state == S_IDLE) && ch_valid && cfg_ok;
    assign accept    = (state == S_FILL) && ch_valid;
    assign cnt_nxt   = cnt + 1'b1;
    assign last      = accept && (hit_lim || ch_eof || ch_err);
    assign word_done = accept && ((cnt_nxt[LANE_W-1:0] == '0) || last);
    assign wr_fire   = (state == S_WRITE) && mem_ready;

    rxpk_len_ctrl #(.LW(LW)) u_len (
        .clk     (clk),
        .rst_n   (rst_n),
        .open    (open),
        .lim_in  (cfg_maxlen),
        .accept  (accept),
        .cnt     (cnt),
        .lim     (lim),
        .hit_lim (hit_lim)
    );

    rxpk_lane_map u_map (
        .order (ord_q),
        .pos   (cnt[LANE_W-1:0]),
        .lane  (lane)
    );

    rxpk_word_acc u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .clear (wr_fire),
        .lane  (lane),
        .din   (ch_data),
        .word  (mem_data),
        .be    (mem_be)
    );

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE:  if (open)      state_nxt = S_FILL;
            S_FILL:  if (word_done) state_nxt = S_WRITE;
            S_WRITE: if (mem_ready) state_nxt = close_q ? S_CLOSE : S_FILL;
            S_CLOSE:                state_nxt = S_IDLE;
            default:                state_nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    // per-buffer context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ord_q     <= 2'b10;
            at_q      <= '0;
            base_q    <= '0;
            widx_q    <= '0;
            close_q   <= 1'b0;
            eof_q     <= 1'b0;
            err_q     <= 1'b0;
            cfg_err_q <= 1'b0;
        end else begin
            cfg_err_q <= !cfg_ok;
            if (open) begin
                ord_q   <= cfg_ctrl[4:3];
                at_q    <= cfg_ctrl[2:0];
                base_q  <= buf_base;
                widx_q  <= '0;
                close_q <= 1'b0;
                eof_q   <= 1'b0;
                err_q   <= 1'b0;
            end
            if (accept && last) begin
                close_q <= 1'b1;
                eof_q   <= ch_eof;
                err_q   <= ch_err;
            end
            if (wr_fire) widx_q <= widx_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        ch_ready  = (state == S_FILL);
        mem_valid = (state == S_WRITE);
        st_valid  = (state == S_CLOSE);
        st_count  = cnt;
        st_eof    = eof_q;
        st_err    = err_q;
        mem_addr  = base_q + (AW'(widx_q) << LANE_W);
        mem_fc    = {at_q, 1'b1};
        cfg_error = cfg_err_q;
    end

    // R12
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_data) && $stable(mem_addr));

    // R11
    status_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |=> !st_valid);

    // R10
    be_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> $countones(mem_be) >= 1);

    // R7
    no_open_on_bad_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) && !cfg_ok |=> !ch_ready);

endmodule

// File: tb/rxpk_top_tb.sv
module rxpk_top_tb;

    localparam int AW = 32;
    localparam int LW = 16;
    localparam int NV = 8;
    localparam int MX = 32;

    // {rsv[26:24], order[23:22], atype[21:19], wide[18], term[17:16], max[15:8], nbytes[7:0]}
    // term: 0 none, 1 end-of-frame, 2 error on the last byte
    localparam logic [26:0] VEC [NV] = '{
        {3'b000, 2'b10, 3'b101, 1'b0, 2'd1, 8'd16, 8'd6},
        {3'b000, 2'b01, 3'b011, 1'b0, 2'd0, 8'd8,  8'd8},
        {3'b000, 2'b00, 3'b000, 1'b0, 2'd2, 8'd20, 8'd7},
        {3'b111, 2'b11, 3'b111, 1'b0, 2'd1, 8'd5,  8'd12},
        {3'b000, 2'b01, 3'b010, 1'b0, 2'd1, 8'd3,  8'd3},
        {3'b000, 2'b10, 3'b110, 1'b1, 2'd1, 8'd4,  8'd9},
        {3'b000, 2'b00, 3'b001, 1'b0, 2'd0, 8'd1,  8'd3},
        {3'b101, 2'b10, 3'b100, 1'b0, 2'd1, 8'd2,  8'd1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] cfg_ctrl = 8'h10;
    logic [LW-1:0] cfg_maxlen = 16'd16;
    logic cfg_wide = 1'b0;
    logic [AW-1:0] buf_base = '0;
    logic ch_valid = 1'b0, ch_eof = 1'b0, ch_err = 1'b0;
    logic [7:0] ch_data = '0;
    logic mem_ready = 1'b1;
    logic ch_ready, mem_valid, st_valid, st_eof, st_err, cfg_error;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_data;
    logic [3:0] mem_be, mem_fc;
    logic [LW-1:0] st_count;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    int nw = 0, ns = 0;
    logic [AW-1:0] g_addr [MX];
    logic [31:0]   g_data [MX];
    logic [3:0]    g_be   [MX];
    logic [3:0]    g_fc   [MX];
    logic [LW-1:0] g_cnt  [MX];
    logic          g_eof  [MX];
    logic          g_err  [MX];

    always #5 clk = ~clk;

    rxpk_top #(.AW(AW), .LW(LW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_ctrl(cfg_ctrl), .cfg_maxlen(cfg_maxlen),
        .cfg_wide(cfg_wide), .buf_base(buf_base), .ch_valid(ch_valid),
        .ch_ready(ch_ready), .ch_data(ch_data), .ch_eof(ch_eof), .ch_err(ch_err),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_be(mem_be), .mem_fc(mem_fc),
        .st_valid(st_valid), .st_count(st_count), .st_eof(st_eof),
        .st_err(st_err), .cfg_error(cfg_error)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_valid && mem_ready) begin
                if (nw < MX) begin
                    g_addr[nw] = mem_addr; g_data[nw] = mem_data;
                    g_be[nw] = mem_be;     g_fc[nw] = mem_fc;
                end
                nw++;
            end
            if (st_valid) begin
                if (ns < MX) begin
                    g_cnt[ns] = st_count; g_eof[ns] = st_eof; g_err[ns] = st_err;
                end
                ns++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] d, input logic e, input logic r);
        @(negedge clk);
        ch_valid = 1'b1; ch_data = d; ch_eof = e; ch_err = r;
        while (!ch_ready) @(negedge clk);
        @(negedge clk);
        ch_valid = 1'b0; ch_eof = 1'b0; ch_err = 1'b0;
    endtask

    task automatic clear_mon();
        @(posedge clk);
        nw = 0; ns = 0;
    endtask

    function automatic logic [1:0] lane_of(input logic [1:0] ord, input int pos);
        logic [1:0] p = 2'(pos);
        if (ord[1])      return 2'd3 - p;   // R1
        else if (ord[0]) return p;          // R2
        else             return (2'd3 - p) ^ 2'd2;  // R3
    endfunction

    task automatic run_vec(input int v);
        logic [2:0] rsv = VEC[v][26:24];
        logic [1:0] ord = VEC[v][23:22];
        logic [2:0] at  = VEC[v][21:19];
        logic wide      = VEC[v][18];
        logic [1:0] term = VEC[v][17:16];
        int mx = int'(VEC[v][15:8]);
        int nb = int'(VEC[v][7:0]);
        logic [AW-1:0] base = AW'((v + 1) * 256);
        logic [AW-1:0] e_addr [MX];
        logic [31:0]   e_data [MX];
        logic [3:0]    e_be   [MX];
        int e_cnt [MX];
        logic e_eof [MX], e_err [MX];
        int wi = 0, si = 0, bcnt = 0, widx = 0;
        logic [31:0] wacc = '0;
        logic [3:0] bacc = '0;

        for (int k = 0; k < nb; k++) begin
            logic [7:0] b = 8'((v * 37) + (k * 13) + 1);
            logic [1:0] ln = lane_of(ord, bcnt % 4);
            bit lst = (k == nb - 1);
            wacc[ln*8 +: 8] = b;
            bacc[ln] = 1'b1;
            bcnt++;
            if ((bcnt % 4 == 0) || (bcnt == mx) || lst) begin
                e_addr[wi] = base + AW'(4 * widx);
                e_data[wi] = wacc; e_be[wi] = bacc;
                wi++; widx++; wacc = '0; bacc = '0;
            end
            if ((bcnt == mx) || lst) begin
                e_cnt[si] = bcnt;
                e_eof[si] = lst && (term == 2'd1);
                e_err[si] = lst && (term == 2'd2);
                si++; bcnt = 0; widx = 0;
            end
        end

        @(negedge clk);
        cfg_ctrl = {rsv, ord, at}; cfg_maxlen = LW'(mx); cfg_wide = wide; buf_base = base;
        clear_mon();
        for (int k = 0; k < nb; k++) begin
            bit lst = (k == nb - 1);
            send(8'((v * 37) + (k * 13) + 1), lst && (term == 2'd1), lst && (term == 2'd2));
        end
        repeat (10) @(negedge clk);

        chk(nw == wi, "R4", $sformatf("vec%0d write count", v), 64'(nw), 64'(wi));
        chk(ns == si, "R11", $sformatf("vec%0d status count", v), 64'(ns), 64'(si));
        for (int i = 0; i < wi && i < nw; i++) begin
            chk(g_data[i] == e_data[i], ord[1] ? "R1" : (ord[0] ? "R2" : "R3"),
                $sformatf("vec%0d word%0d data", v, i), 64'(g_data[i]), 64'(e_data[i]));
            chk(g_be[i] == e_be[i], "R10", $sformatf("vec%0d word%0d be", v, i),
                64'(g_be[i]), 64'(e_be[i]));
            chk(g_addr[i] == e_addr[i], "R13", $sformatf("vec%0d word%0d addr", v, i),
                64'(g_addr[i]), 64'(e_addr[i]));
            chk(g_fc[i] == {at, 1'b1}, "R8_R9", $sformatf("vec%0d word%0d fc", v, i),
                64'(g_fc[i]), 64'({at, 1'b1}));
        end
        for (int i = 0; i < si && i < ns; i++) begin
            chk(g_cnt[i] == LW'(e_cnt[i]), "R4", $sformatf("vec%0d buf%0d count", v, i),
                64'(g_cnt[i]), 64'(e_cnt[i]));
            chk({g_eof[i], g_err[i]} == {e_eof[i], e_err[i]}, "R5",
                $sformatf("vec%0d buf%0d eof/err", v, i),
                64'({g_eof[i], g_err[i]}), 64'({e_eof[i], e_err[i]}));
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] held;
        // reset state
        repeat (3) @(negedge clk);
        chk({ch_ready, mem_valid, st_valid} == 3'b000, "R11", "reset outputs",
            64'({ch_ready, mem_valid, st_valid}), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(cfg_error == 1'b0, "R7", "cfg_error after reset", 64'(cfg_error), 64'd0);

        for (int v = 0; v < NV; v++) run_vec(v);

        // R7: zero length blocks opening
        clear_mon();
        @(negedge clk);
        cfg_ctrl = 8'h10; cfg_maxlen = '0; cfg_wide = 1'b0; buf_base = 32'h4000;
        ch_valid = 1'b1; ch_data = 8'hA5; ch_eof = 1'b1;
        repeat (4) @(negedge clk);
        chk(cfg_error == 1'b1 && ch_ready == 1'b0, "R7", "zero length",
            64'({cfg_error, ch_ready}), 64'b10);
        // R7: odd length with wide characters
        cfg_maxlen = 16'd5; cfg_wide = 1'b1;
        repeat (4) @(negedge clk);
        chk(cfg_error == 1'b1 && ch_ready == 1'b0, "R7", "odd length wide",
            64'({cfg_error, ch_ready}), 64'b10);
        chk(nw == 0 && ns == 0, "R7", "no activity on bad cfg", 64'(nw + ns), 64'd0);
        cfg_maxlen = 16'd4;
        while (!ch_ready) @(negedge clk);
        chk(cfg_error == 1'b0, "R7", "legal length clears", 64'(cfg_error), 64'd0);
        @(negedge clk);
        ch_valid = 1'b0; ch_eof = 1'b0; cfg_wide = 1'b0;
        repeat (6) @(negedge clk);
        chk(ns == 1 && g_cnt[0] == 16'd1 && g_eof[0], "R5", "eof after cfg fix",
            64'({ns[7:0], g_cnt[0], 7'd0, g_eof[0]}), 64'({8'd1, 16'd1, 8'd1}));

        // R6: length change inside an open buffer
        clear_mon();
        cfg_ctrl = 8'h10; cfg_maxlen = 16'd6; buf_base = 32'h5000;
        send(8'h01, 1'b0, 1'b0);
        send(8'h02, 1'b0, 1'b0);
        cfg_maxlen = 16'd3;
        for (int k = 0; k < 4; k++) send(8'(8'h03 + k), 1'b0, 1'b0);
        for (int k = 0; k < 3; k++) send(8'(8'h10 + k), 1'b0, 1'b0);
        repeat (8) @(negedge clk);
        chk(ns == 2, "R6", "two buffers", 64'(ns), 64'd2);
        chk(g_cnt[0] == 16'd6, "R6", "old limit kept", 64'(g_cnt[0]), 64'd6);
        chk(g_cnt[1] == 16'd3, "R6", "new limit next buffer", 64'(g_cnt[1]), 64'd3);

        // R12: stalled write holds the character stream
        clear_mon();
        cfg_maxlen = 16'd8; buf_base = 32'h6000; mem_ready = 1'b0;
        for (int k = 0; k < 4; k++) send(8'(8'h20 + k), 1'b0, 1'b0);
        @(negedge clk);
        ch_valid = 1'b1; ch_data = 8'h24;
        held = mem_data;
        repeat (3) @(negedge clk);
        chk(mem_valid && !ch_ready, "R12", "stall holds input",
            64'({mem_valid, ch_ready}), 64'b10);
        chk(mem_data == held && held == 32'h20212223, "R12", "stalled data stable",
            64'(mem_data), 64'h20212223);
        mem_ready = 1'b1;
        ch_valid = 1'b0;
        for (int k = 0; k < 4; k++) send(8'(8'h24 + k), 1'b0, 1'b0);
        repeat (8) @(negedge clk);
        chk(nw == 2 && g_data[1] == 32'h24252627, "R12", "no byte lost",
            64'(g_data[1]), 64'h24252627);
        chk(ns == 1 && g_cnt[0] == 16'd8, "R4", "stalled buffer count",
            64'(g_cnt[0]), 64'd8);

        finish_run();
    end

endmodule